// File: doc/BRIEF.md
# Receiver Lock Monitor with Reference Fallback

This block watches the sampled serial stream of a receiver and decides whether clock recovery can be trusted. It uses two independent health checks. The first is a run-length watchdog that counts identical consecutive bits. The second is a frequency window that counts recovered bit ticks over a fixed number of reference ticks and compares the total against a band set in ppm. The data itself only matters through its transitions, so an abrupt phase slip in the stream is invisible to both checks.

When either check fails, or when the active-low force input is held low, the block asks for the reference clock to drive the downstream word clock. The select output is registered and changes only at word boundaries, so a glitch-free clock mux placed after it always switches between whole words. Lock is first reached once a run of clean bits has been seen. After a frequency failure, lock also waits for a window that passes.

Top module: `rx_lock_detect`

## Requirements
- R1: After reset, with a stream that never violates the run limit, `lock_o` is low after 249 bit ticks and high after the 250th bit tick (LOCK_BITS=250).
- R2: A run of exactly RUN_LIMIT identical bits (default 120) keeps lock. The bit tick that carries identical bit number RUN_LIMIT+1 drops `lock_o` right after that edge.
- R3: At the end of a window of 2^WIN_LOG2 reference ticks, if the bit-tick count lies outside NOM±NOM·PPM_TOL/10^6 (NOM = 2^WIN_LOG2·BITS_PER_REF), `lock_o` drops right after that edge.
- R4: A bit-tick count inside that band leaves `lock_o` high.
- R5: A sudden phase slip of the data pattern, with an unchanged bit-tick rate, does not drop lock.
- R6: After a run-length loss, with no frequency failure pending, lock returns at the 250th consecutive clean bit tick without waiting for a window.
- R7: After a frequency failure, lock stays low even once the clean bit run is complete, and returns only at the end of a window that passes.
- R8: While `force_ref_ni` is low, `sel_ref_o` goes to 1 (reference) at the next word boundary, and `lock_o` keeps reporting data lock.
- R9: `sel_ref_o` changes only right after a word boundary, which is every WORD_BITS (10) bit ticks counted from reset.
- R10: During and right after reset, `lock_o`=0 and `sel_ref_o`=1.
- R11: At a word boundary, `sel_ref_o` becomes 1 when unlocked, and 0 when locked with force released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Sampled serial data, valid when bit_tick_i is high |
| bit_tick_i | input | 1 | One pulse per recovered bit |
| ref_tick_i | input | 1 | One pulse per reference clock cycle |
| force_ref_ni | input | 1 | Low forces the reference clock as the source |
| lock_o | output | 1 | High when the receiver is locked to the data |
| sel_ref_o | output | 1 | 1 selects the reference clock, 0 the recovered clock |

## Verification
The hardest state to reach is a failed frequency window followed by a clean stream. There, lock must stay low while the run counter is already satisfied, and must rise exactly when the next window closes. The bench reaches this state by dropping one bit tick in every 40 cycles for two whole windows, and uses one in 100 as an in-band drift. It tracks window ends from its own count of reference ticks, so it can sample just before and just after the passing window. The run-limit boundary is checked with runs of RUN_LIMIT and RUN_LIMIT+1 ones that start right after a zero.

// File: rtl/rxld_pkg.sv
package rxld_pkg;
  // allowed deviation in counts for a nominal count and a ppm tolerance
  function automatic int ppm_span(input int nom, input int ppm);
    longint prod;
    prod = longint'(nom) * longint'(ppm);
    return int'(prod / 64'd1000000);
  endfunction
endpackage

// File: rtl/rxld_run_mon.sv
module rxld_run_mon #(
  parameter int RUN_LIMIT = 120,
  parameter int LOCK_BITS = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic bit_tick_i,
  output logic viol_o,
  output logic clean_o
);
  localparam int RW = $clog2(RUN_LIMIT + 1);
  localparam int GW = $clog2(LOCK_BITS + 1);

  logic          prev_q;
  logic [RW-1:0] run_q;
  logic [GW-1:0] good_q;
  logic          trans;

  assign trans  = data_i ^ prev_q;
  assign viol_o = bit_tick_i && !trans && (run_q >= RW'(RUN_LIMIT));
  assign clean_o = (good_q == GW'(LOCK_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      run_q  <= '0;
      good_q <= '0;
    end else if (bit_tick_i) begin
      prev_q <= data_i;
      if (trans)                          run_q <= RW'(1);
      else if (run_q < RW'(RUN_LIMIT))    run_q <= run_q + RW'(1);
      if (viol_o)                         good_q <= '0;
      else if (good_q != GW'(LOCK_BITS))  good_q <= good_q + GW'(1);
    end
  end
endmodule

// File: rtl/rxld_freq_mon.sv
module rxld_freq_mon #(
  parameter int WIN_LOG2     = 14,
  parameter int BITS_PER_REF = 10,
  parameter int PPM_TOL      = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic ref_tick_i,
  output logic win_end_o,
  output logic win_pass_o,
  output logic freq_bad_o
);
  localparam int NOM = (2 ** WIN_LOG2) * BITS_PER_REF;
  localparam int DEV = rxld_pkg::ppm_span(NOM, PPM_TOL);
  localparam int LO  = NOM - DEV;
  localparam int HI  = NOM + DEV;
  localparam int CW  = $clog2(2 * NOM + 1);

  logic [WIN_LOG2-1:0] ref_q;
  logic [CW-1:0]       cnt_q, cnt_inc, total;
  logic                bad_q;

  assign cnt_inc    = (&cnt_q) ? cnt_q : cnt_q + CW'(1);
  assign total      = bit_tick_i ? cnt_inc : cnt_q;
  assign win_end_o  = ref_tick_i && (&ref_q);
  assign win_pass_o = (total >= CW'(LO)) && (total <= CW'(HI));
  assign freq_bad_o = bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else begin
      if (ref_tick_i) ref_q <= ref_q + WIN_LOG2'(1);
      if (win_end_o) begin
        cnt_q <= '0;
        bad_q <= !win_pass_o;
      end else begin
        cnt_q <= total;
      end
    end
  end
endmodule

// File: rtl/rxld_src_sel.sv
module rxld_src_sel #(
  parameter int WORD_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic want_ref_i,
  output logic word_end_o,
  output logic sel_ref_o
);
  localparam int WW = $clog2(WORD_BITS);

  logic [WW-1:0] word_q;
  logic          sel_q;

  assign word_end_o = bit_tick_i && (word_q == WW'(WORD_BITS - 1));
  assign sel_ref_o  = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      sel_q  <= 1'b1;
    end else if (bit_tick_i) begin
      word_q <= word_end_o ? '0 : word_q + WW'(1);
      if (word_end_o) sel_q <= want_ref_i;  // switch only between words
    end
  end
endmodule

// File: rtl/rx_lock_detect.sv
module rx_lock_detect #(
  parameter int RUN_LIMIT    = 120,
  parameter int LOCK_BITS    = 250,
  parameter int WIN_LOG2     = 14,
  parameter int BITS_PER_REF = 10,
  parameter int PPM_TOL      = 600,
  parameter int WORD_BITS    = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic bit_tick_i,
  input  logic ref_tick_i,
  input  logic force_ref_ni,
  output logic lock_o,
  output logic sel_ref_o
);
  logic run_viol, run_clean;
  logic win_end, win_pass, freq_bad;
  logic word_end, want_ref;

  rxld_run_mon #(.RUN_LIMIT(RUN_LIMIT), .LOCK_BITS(LOCK_BITS)) u_run (
    .clk_i, .rst_ni, .data_i, .bit_tick_i,
    .viol_o(run_viol), .clean_o(run_clean)
  );

  rxld_freq_mon #(.WIN_LOG2(WIN_LOG2), .BITS_PER_REF(BITS_PER_REF),
                  .PPM_TOL(PPM_TOL)) u_freq (
    .clk_i, .rst_ni, .bit_tick_i, .ref_tick_i,
    .win_end_o(win_end), .win_pass_o(win_pass), .freq_bad_o(freq_bad)
  );

  assign lock_o   = run_clean && !freq_bad;
  assign want_ref = !lock_o || !force_ref_ni;

  rxld_src_sel #(.WORD_BITS(WORD_BITS)) u_sel (
    .clk_i, .rst_ni, .bit_tick_i, .want_ref_i(want_ref),
    .word_end_o(word_end), .sel_ref_o
  );
endmodule

// File: rtl/rx_lock_detect_chk.sv
module rx_lock_detect_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic force_ref_ni,
  input logic lock_o,
  input logic sel_ref_o,
  input logic word_end_i,
  input logic run_viol_i,
  input logic win_end_i,
  input logic win_pass_i
);
  // R9
  sel_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_ref_o) |-> $past(word_end_i));
  // R8
  force_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_end_i && !force_ref_ni) |=> sel_ref_o);
  // R2
  run_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_viol_i |=> !lock_o);
  // R3
  freq_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_end_i && !win_pass_i) |=> !lock_o);
  // R11
  unlock_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_end_i && !lock_o) |=> sel_ref_o);
endmodule

bind rx_lock_detect rx_lock_detect_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .force_ref_ni(force_ref_ni),
  .lock_o(lock_o), .sel_ref_o(sel_ref_o), .word_end_i(word_end),
  .run_viol_i(run_viol), .win_end_i(win_end), .win_pass_i(win_pass)
);

// File: tb/rx_lock_detect_test.sv
module rx_lock_detect_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni = 1'b0, data_i = 1'b0, bit_tick_i = 1'b0, ref_tick_i = 1'b0;
  logic force_ref_ni = 1'b1;
  logic lock_o, sel_ref_o;

  // window 256 ref ticks, nominal 2560 bits, band +-51
  rx_lock_detect #(.WIN_LOG2(8), .PPM_TOL(20000)) uut (
    .clk_i(clk), .rst_ni, .data_i, .bit_tick_i, .ref_tick_i,
    .force_ref_ni, .lock_o, .sel_ref_o
  );

  typedef struct {
    string tag;
    logic  exp_lock;
    bit    use_lock;
    logic  exp_sel;
    bit    use_sel;
  } item_t;
  item_t sbq[$];

  int checks = 0, fails = 0;
  int cyc = 0, skip_per = 0, pat_idx = 0;
  int ticks = 0, refs = 0, win_ends = 0;
  bit finished = 0;
  logic prev_sel = 1'b1;
  logic [9:0] pat = 10'b0101111100;  // bit 0 sent first, ends on a 0

  task automatic expect_out(input string tag, input logic l, input bit ul,
                            input logic s, input bit us);
    item_t it;
    it.tag = tag; it.exp_lock = l; it.use_lock = ul; it.exp_sel = s; it.use_sel = us;
    sbq.push_back(it);
  endtask

  task automatic step(input bit is_const, input logic val);
    bit tk;
    @(negedge clk);
    cyc++;
    ref_tick_i = (cyc % 10 == 0);
    tk = !(skip_per != 0 && cyc % skip_per == 0);
    bit_tick_i = tk;
    if (tk) begin
      if (is_const) data_i = val;
      else begin
        data_i = pat[pat_idx];
        pat_idx = (pat_idx + 1) % 10;
      end
    end
  endtask

  task automatic send_pat(input int n);
    int k = 0;
    while (k < n) begin
      step(1'b0, 1'b0);
      if (bit_tick_i) k++;
    end
  endtask

  task automatic send_const(input int n, input logic v);
    int k = 0;
    while (k < n) begin
      step(1'b1, v);
      if (bit_tick_i) k++;
    end
  endtask

  task automatic wait_windows(input int n);
    int start = win_ends;
    while (win_ends < start + n) step(1'b0, 1'b0);
  endtask

  // bench view of bit ticks and window ends
  always @(posedge clk) begin
    if (rst_ni) begin
      if (bit_tick_i) ticks++;
      if (ref_tick_i) begin
        refs++;
        if (refs % 256 == 0) win_ends++;
      end
    end
  end

  // monitor: pops expected items and checks word alignment of select changes
  always @(posedge clk) begin
    #2;
    if (rst_ni && sel_ref_o !== prev_sel) begin
      checks++;
      if (ticks % 10 != 0) begin
        fails++;
        $display("FAIL R9 sel change at tick %0d: actual tick%%10=%0d expected 0",
                 ticks, ticks % 10);
      end
    end
    prev_sel = sel_ref_o;
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      if (it.use_lock) begin
        checks++;
        if (lock_o !== it.exp_lock) begin
          fails++;
          $display("FAIL %s lock_o actual=%b expected=%b", it.tag, lock_o, it.exp_lock);
        end
      end
      if (it.use_sel) begin
        checks++;
        if (sel_ref_o !== it.exp_sel) begin
          fails++;
          $display("FAIL %s sel_ref_o actual=%b expected=%b", it.tag, sel_ref_o, it.exp_sel);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R10", 1'b0, 1, 1'b1, 1);
    @(negedge clk);
    rst_ni = 1'b1;
    expect_out("R10", 1'b0, 1, 1'b1, 1);

    // R1: lock at the 250th clean bit, select follows at the next word end
    send_pat(249);
    expect_out("R1", 1'b0, 1, 1'b1, 1);
    send_pat(1);
    expect_out("R1", 1'b1, 1, 1'b1, 1);
    send_pat(10);
    expect_out("R11", 1'b1, 1, 1'b0, 1);

    // R2: run of RUN_LIMIT is fine, RUN_LIMIT+1 loses lock
    send_const(120, 1'b1);
    expect_out("R2", 1'b1, 1, 1'b0, 0);
    send_pat(10);
    send_const(120, 1'b1);
    expect_out("R2", 1'b1, 1, 1'b0, 0);
    send_const(1, 1'b1);
    expect_out("R2", 1'b0, 1, 1'b0, 0);

    // R6: relock after 250 clean bits, no window needed
    send_pat(249);
    expect_out("R6", 1'b0, 1, 1'b1, 1);
    send_pat(1);
    expect_out("R6", 1'b1, 1, 1'b0, 0);
    send_pat(20);
    expect_out("R11", 1'b1, 1, 1'b0, 1);

    // R5: phase slip of the data pattern
    pat_idx = (pat_idx + 3) % 10;
    send_pat(200);
    expect_out("R5", 1'b1, 1, 1'b0, 1);

    // R8: forced reference
    force_ref_ni = 1'b0;
    send_pat(20);
    expect_out("R8", 1'b1, 1, 1'b1, 1);
    force_ref_ni = 1'b1;
    send_pat(20);
    expect_out("R8", 1'b1, 1, 1'b0, 1);

    // R4: drift inside the band (1 in 100 ticks missing)
    skip_per = 100;
    wait_windows(3);
    expect_out("R4", 1'b1, 1, 1'b0, 1);

    // R3: drift outside the band (1 in 40 ticks missing)
    skip_per = 40;
    wait_windows(2);
    expect_out("R3", 1'b0, 1, 1'b0, 0);
    send_pat(20);
    expect_out("R3", 1'b0, 1, 1'b1, 1);

    // R7: clean run alone does not relock, the passing window does
    skip_per = 0;
    send_pat(1000);
    expect_out("R7", 1'b0, 1, 1'b1, 1);
    wait_windows(1);
    expect_out("R7", 1'b1, 1, 1'b0, 0);
    send_pat(20);
    expect_out("R11", 1'b1, 1, 1'b0, 1);

    @(posedge clk);
    #4;
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule